// File: doc/BRIEF.md
# Serial Flash Deep Sleep and Legacy Signature Responder

This block is the slave-side command logic of a serial flash device for one instruction family. It decodes the wake-and-identify instruction and the power-down instruction. It also tracks three power conditions. The serial interface is chip select, clock and data in, and the block drives a data-out line with its own enable. It accepts SPI mode 0 and mode 3 traffic. All serial inputs are oversampled by a fast system clock, so the serial clock must run well below the system clock.

The wake-and-identify instruction has two jobs. From standby it returns the fixed one-byte legacy signature. The byte follows the opcode and 24 dummy bits, and it repeats with no gap for as long as the host keeps clocking. From deep power-down it does the same, and it also starts a wake-up interval when chip select rises. That interval is a fixed number of system clocks, and the block returns to standby when it ends. While the device sleeps, every other opcode is dropped. While the external busy flag is high, neither instruction is decoded.

Top module: `flash_sig_responder`

## Requirements
- R1: After reset the power state is standby (encoding 0) and `miso_oe` is low.
- R2: Data-in bits are taken on rising serial-clock edges, most significant bit first. After the 8-bit opcode 8'hAB and 24 dummy bits, the 8-bit signature 8'h14 is driven most significant bit first. Each bit changes on a falling serial-clock edge and is valid at the following rising edge. `miso_oe` stays low during the opcode and the dummy bits.
- R3: While chip select stays low and the clock keeps running, the signature byte repeats back to back with no gap.
- R4: Opcode 8'hAB issued from standby returns the signature and leaves the power state at standby.
- R5: Opcode 8'hB9 moves standby to deep power-down (encoding 1) when chip select rises, but only if exactly 8 bits were clocked in that selection. With 7 or 9 bits it has no effect.
- R6: In deep power-down, any opcode other than 8'hAB, including 8'hB9, is ignored. `miso_oe` stays low and the state stays deep power-down.
- R7: Opcode 8'hAB in deep power-down returns the signature. When chip select rises, the state becomes waking (encoding 2) for exactly WAKE_CYCLES system clocks, and then becomes standby.
- R8: If `busy` is high when the eighth opcode bit is taken, neither 8'hAB nor 8'hB9 is decoded. `miso_oe` stays low and the power state does not change.
- R9: A selection that begins while the state is waking is ignored for its whole length, even if the delay ends before chip select rises. No data is driven and no state change follows.
- R10: `miso_oe` falls within a few system clocks after chip select rises, and the next selection starts a fresh bit count.
- R11: Mode 0 (clock idle low) and mode 3 (clock idle high) give the same results.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the serial interface |
| rst_n | input | 1 | Active-low asynchronous reset |
| cs_n | input | 1 | Active-low chip select |
| sclk | input | 1 | Serial clock |
| mosi | input | 1 | Serial data in |
| busy | input | 1 | High while an erase, program or status-write cycle runs |
| miso | output | 1 | Serial data out |
| miso_oe | output | 1 | Output enable for `miso`; low means high-impedance |
| pwr_state | output | 2 | Power state: 0 standby, 1 deep power-down, 2 waking |

## Verification
The hardest case to reach from the ports is a selection that starts inside the wake-up interval and ends after it. The bench reaches it by putting the device to sleep and waking it with the signature instruction. It then opens a new 48-bit signature frame a few clocks after chip select rises. That frame takes far longer than the delay, so it stays open after the state has already returned to standby. The other narrow case is `busy` at the exact eighth opcode bit. The bench holds `busy` for the whole frame, both in standby with the sleep opcode and in deep power-down with the wake opcode. In each case it then checks that nothing was driven and that the power state did not move.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    typedef enum logic [1:0] {
        PWR_STANDBY = 2'd0,
        PWR_DEEP    = 2'd1,
        PWR_WAKE    = 2'd2
    } pwr_state_t;

    typedef enum logic [2:0] {
        FR_IDLE   = 3'd0,
        FR_OPCODE = 3'd1,
        FR_DUMMY  = 3'd2,
        FR_SIG    = 3'd3,
        FR_ARMED  = 3'd4,
        FR_IGNORE = 3'd5
    } frame_state_t;

    localparam int OP_BITS = 8;

endpackage

// File: rtl/fsr_sync.sv
module fsr_sync #(
    parameter int         STAGES    = 2,
    parameter int         WIDTH     = 3,
    parameter logic [2:0] RESET_VAL = 3'b001
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] pipe [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= WIDTH'(RESET_VAL);
        end else begin
            pipe[0] <= d;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
        end
    end

    assign q = pipe[STAGES-1];
endmodule

// File: rtl/fsr_frame_fsm.sv
module fsr_frame_fsm
    import fsr_pkg::*;
#(
    parameter logic [7:0] OP_RELEASE = 8'hAB,
    parameter logic [7:0] OP_SLEEP   = 8'hB9,
    parameter int         DUMMY_BITS = 24
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         cs_rise,
    input  logic         cs_fall,
    input  logic         sclk_rise,
    input  logic         mosi_s,
    input  logic         busy,
    input  pwr_state_t   pwr,
    output frame_state_t frame,
    output logic         in_sig,
    output logic         sleep_req,
    output logic         wake_req
);
    localparam int MAX_BITS = (DUMMY_BITS > OP_BITS) ? DUMMY_BITS : OP_BITS;
    localparam int CNT_W    = $clog2(MAX_BITS + 1);

    frame_state_t       state_q, state_d;
    logic [CNT_W-1:0]   bit_cnt;
    logic [OP_BITS-1:0] shreg;
    logic               release_seen;
    logic [OP_BITS-1:0] opcode_now;
    logic               last_op_bit;
    logic               last_dummy_bit;
    logic               op_release_ok;
    logic               op_sleep_ok;

    assign opcode_now     = {shreg[OP_BITS-2:0], mosi_s};
    assign last_op_bit    = sclk_rise && (bit_cnt == CNT_W'(OP_BITS - 1));
    assign last_dummy_bit = sclk_rise && (bit_cnt == CNT_W'(DUMMY_BITS - 1));
    assign op_release_ok  = !busy && (opcode_now == OP_RELEASE);
    assign op_sleep_ok    = !busy && (opcode_now == OP_SLEEP) && (pwr == PWR_STANDBY);

    // next-state logic
    always_comb begin
        state_d = state_q;
        if (cs_rise) begin
            state_d = FR_IDLE;
        end else begin
            unique case (state_q)
                FR_IDLE: begin
                    if (cs_fall) state_d = (pwr == PWR_WAKE) ? FR_IGNORE : FR_OPCODE;
                end
                FR_OPCODE: begin
                    if (last_op_bit) begin
                        if (op_release_ok)    state_d = FR_DUMMY;
                        else if (op_sleep_ok) state_d = FR_ARMED;
                        else                  state_d = FR_IGNORE;
                    end
                end
                FR_DUMMY: begin
                    if (last_dummy_bit) state_d = FR_SIG;
                end
                FR_SIG: state_d = FR_SIG;
                FR_ARMED: begin
                    if (sclk_rise) state_d = FR_IGNORE;
                end
                FR_IGNORE: state_d = FR_IGNORE;
                default:   state_d = FR_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FR_IDLE;
        else        state_q <= state_d;
    end

    // bit counter, opcode shifter, release flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_cnt      <= '0;
            shreg        <= '0;
            release_seen <= 1'b0;
        end else begin
            if (state_d != state_q || cs_fall) begin
                bit_cnt <= '0;
            end else if (sclk_rise && (state_q == FR_OPCODE || state_q == FR_DUMMY)) begin
                bit_cnt <= bit_cnt + 1'b1;
            end

            if (sclk_rise && state_q == FR_OPCODE) shreg <= opcode_now;

            if (state_q == FR_IDLE) begin
                release_seen <= 1'b0;
            end else if (state_q == FR_OPCODE && last_op_bit && op_release_ok && !cs_rise) begin
                release_seen <= 1'b1;
            end
        end
    end

    // outputs
    always_comb begin
        frame     = state_q;
        in_sig    = (state_q == FR_SIG);
        sleep_req = cs_rise && (state_q == FR_ARMED);
        wake_req  = cs_rise && release_seen;
    end
endmodule

// File: rtl/fsr_power_fsm.sv
module fsr_power_fsm
    import fsr_pkg::*;
#(
    parameter int WAKE_CYCLES = 64
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sleep_req,
    input  logic       wake_req,
    output pwr_state_t pwr,
    output logic       wake_left
);
    localparam int WCNT_W = $clog2(WAKE_CYCLES + 1);

    pwr_state_t        state_q, state_d;
    logic [WCNT_W-1:0] wcnt;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            PWR_STANDBY: if (sleep_req)       state_d = PWR_DEEP;
            PWR_DEEP:    if (wake_req)        state_d = PWR_WAKE;
            PWR_WAKE:    if (wcnt == '0)      state_d = PWR_STANDBY;
            default:                          state_d = PWR_STANDBY;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= PWR_STANDBY;
        else        state_q <= state_d;
    end

    // wake-up interval counter
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wcnt <= '0;
        end else if (state_q == PWR_DEEP && wake_req) begin
            wcnt <= WCNT_W'(WAKE_CYCLES - 1);
        end else if (state_q == PWR_WAKE && wcnt != '0) begin
            wcnt <= wcnt - 1'b1;
        end
    end

    // outputs
    always_comb begin
        pwr       = state_q;
        wake_left = (wcnt != '0);
    end
endmodule

// File: rtl/fsr_sig_shifter.sv
module fsr_sig_shifter #(
    parameter int                SIG_BITS  = 8,
    parameter logic [SIG_BITS-1:0] SIG_VALUE = 8'h14
) (
    input  logic clk,
    input  logic rst_n,
    input  logic in_sig,
    input  logic sclk_fall,
    output logic dout,
    output logic oe
);
    localparam int IDX_W = (SIG_BITS > 1) ? $clog2(SIG_BITS) : 1;

    logic [IDX_W-1:0] idx;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx  <= IDX_W'(SIG_BITS - 1);
            dout <= 1'b0;
            oe   <= 1'b0;
        end else if (!in_sig) begin
            idx  <= IDX_W'(SIG_BITS - 1);
            dout <= 1'b0;
            oe   <= 1'b0;
        end else if (sclk_fall) begin
            dout <= SIG_VALUE[idx];
            oe   <= 1'b1;
            idx  <= (idx == '0) ? IDX_W'(SIG_BITS - 1) : idx - 1'b1;
        end
    end
endmodule

// File: rtl/flash_sig_responder.sv
module flash_sig_responder
    import fsr_pkg::*;
#(
    parameter int         SYNC_STAGES = 2,
    parameter int         WAKE_CYCLES = 64,
    parameter int         DUMMY_BITS  = 24,
    parameter logic [7:0] SIG_VALUE   = 8'h14,
    parameter logic [7:0] OP_RELEASE  = 8'hAB,
    parameter logic [7:0] OP_SLEEP    = 8'hB9
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       cs_n,
    input  logic       sclk,
    input  logic       mosi,
    input  logic       busy,
    output logic       miso,
    output logic       miso_oe,
    output logic [1:0] pwr_state
);
    logic [2:0]   sync_q;
    logic         cs_s, sclk_s, mosi_s;
    logic         cs_q, sclk_q;
    logic         cs_rise, cs_fall, sclk_rise, sclk_fall;
    frame_state_t frame_q;
    pwr_state_t   pwr_q;
    logic         in_sig, sleep_req, wake_req, wake_left;

    fsr_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RESET_VAL(3'b001)) u_sync (
        .clk  (clk),
        .rst_n(rst_n),
        .d    ({mosi, sclk, cs_n}),
        .q    (sync_q)
    );

    assign cs_s   = sync_q[0];
    assign sclk_s = sync_q[1];
    assign mosi_s = sync_q[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cs_q   <= 1'b1;
            sclk_q <= 1'b0;
        end else begin
            cs_q   <= cs_s;
            sclk_q <= sclk_s;
        end
    end

    assign cs_rise   =  cs_s & ~cs_q;
    assign cs_fall   = ~cs_s &  cs_q;
    assign sclk_rise = ~cs_s &  sclk_s & ~sclk_q;
    assign sclk_fall = ~cs_s & ~sclk_s &  sclk_q;

    fsr_frame_fsm #(
        .OP_RELEASE(OP_RELEASE),
        .OP_SLEEP  (OP_SLEEP),
        .DUMMY_BITS(DUMMY_BITS)
    ) u_frame (
        .clk      (clk),
        .rst_n    (rst_n),
        .cs_rise  (cs_rise),
        .cs_fall  (cs_fall),
        .sclk_rise(sclk_rise),
        .mosi_s   (mosi_s),
        .busy     (busy),
        .pwr      (pwr_q),
        .frame    (frame_q),
        .in_sig   (in_sig),
        .sleep_req(sleep_req),
        .wake_req (wake_req)
    );

    fsr_power_fsm #(.WAKE_CYCLES(WAKE_CYCLES)) u_power (
        .clk      (clk),
        .rst_n    (rst_n),
        .sleep_req(sleep_req),
        .wake_req (wake_req),
        .pwr      (pwr_q),
        .wake_left(wake_left)
    );

    fsr_sig_shifter #(.SIG_BITS(8), .SIG_VALUE(SIG_VALUE)) u_sig (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_sig   (in_sig),
        .sclk_fall(sclk_fall),
        .dout     (miso),
        .oe       (miso_oe)
    );

    assign pwr_state = pwr_q;
endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
#(
    parameter logic [7:0] SIG_VALUE = 8'h14
) (
    input logic         clk,
    input logic         rst_n,
    input pwr_state_t   pwr,
    input logic         wake_left,
    input logic         cs_s,
    input logic         cs_fall,
    input frame_state_t frame,
    input logic         sleep_req,
    input logic         miso,
    input logic         miso_oe
);
    AST_STANDBY_NEVER_WAKES: assert property (@(posedge clk) disable iff (!rst_n)
        pwr == PWR_STANDBY |=> pwr != PWR_WAKE); // R4

    AST_SLEEP_ONLY_FROM_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
        sleep_req |-> pwr == PWR_STANDBY); // R5

    AST_DEEP_EXITS_VIA_WAKE: assert property (@(posedge clk) disable iff (!rst_n)
        pwr == PWR_DEEP |=> (pwr == PWR_DEEP || pwr == PWR_WAKE)); // R7

    AST_WAKE_HOLDS_WHILE_COUNTING: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_WAKE && wake_left) |=> pwr == PWR_WAKE); // R7

    AST_SELECT_IN_WAKE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (pwr == PWR_WAKE && cs_fall) |=> frame == FR_IGNORE); // R9

    AST_QUIET_WHEN_DESELECTED: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_s && $past(cs_s) && $past(cs_s, 2)) |-> !miso_oe); // R10

    AST_SIG_MSB_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(miso_oe) |-> miso == SIG_VALUE[7]); // R2
endmodule

bind flash_sig_responder fsr_checker #(.SIG_VALUE(SIG_VALUE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pwr      (pwr_q),
    .wake_left(wake_left),
    .cs_s     (cs_s),
    .cs_fall  (cs_fall),
    .frame    (frame_q),
    .sleep_req(sleep_req),
    .miso     (miso),
    .miso_oe  (miso_oe)
);

// File: tb/sim_flash_sig_responder.sv
`timescale 1ns/1ps
module sim_flash_sig_responder;
    localparam int WAKE_CYC = 64;
    localparam int HALF     = 8;
    localparam int ST_STBY  = 0;
    localparam int ST_DEEP  = 1;
    localparam int ST_WAKE  = 2;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1;
    logic       sclk = 1'b0;
    logic       mosi = 1'b0;
    logic       busy = 1'b0;
    logic       miso;
    logic       miso_oe;
    logic [1:0] pwr_state;

    int n_cmp = 0;
    int n_bad = 0;
    logic rx_bits [64];
    logic oe_bits [64];

    always #2.5 clk = ~clk;

    flash_sig_responder #(.WAKE_CYCLES(WAKE_CYC)) u0 (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi),
        .busy(busy), .miso(miso), .miso_oe(miso_oe), .pwr_state(pwr_state)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // one selection: opcode, then zeros, nbits clocks in total
    task automatic run_frame(input bit m3, input logic [7:0] op, input int nbits);
        sclk = m3;
        idle(HALF);
        cs_n = 1'b0;
        idle(HALF);
        for (int i = 0; i < nbits; i++) begin
            sclk = 1'b0;
            mosi = (i < 8) ? op[7-i] : 1'b0;
            idle(HALF);
            rx_bits[i] = miso;
            oe_bits[i] = miso_oe;
            sclk = 1'b1;
            idle(HALF);
        end
        sclk = m3;
        idle(HALF);
        cs_n = 1'b1;
    endtask

    function automatic int rx_byte(input int base);
        logic [7:0] b;
        for (int k = 0; k < 8; k++) b[7-k] = rx_bits[base+k];
        return int'(b);
    endfunction

    function automatic int oe_count(input int lo, input int hi);
        int c = 0;
        for (int k = lo; k < hi; k++) c += int'(oe_bits[k]);
        return c;
    endfunction

    task automatic t_reset();
        check("R1", "power after reset", int'(pwr_state), ST_STBY);
        check("R1", "oe after reset", int'(miso_oe), 0);
    endtask

    task automatic t_sig_standby(input bit m3);
        run_frame(m3, 8'hAB, 48);
        check(m3 ? "R2 R11" : "R2", "oe during opcode and dummies", oe_count(0, 32), 0);
        check("R2", "first signature byte", rx_byte(32), 'h14);
        check("R3", "repeated signature byte", rx_byte(40), 'h14);
        check("R3", "oe held over both bytes", oe_count(32, 48), 16);
        idle(8);
        check("R10", "oe after deselect", int'(miso_oe), 0);
        check("R4", "power after signature from standby", int'(pwr_state), ST_STBY);
    endtask

    task automatic t_sleep_counts();
        run_frame(1'b0, 8'hB9, 7);
        idle(8);
        check("R5", "sleep opcode with 7 bits", int'(pwr_state), ST_STBY);
        run_frame(1'b1, 8'hB9, 9);
        idle(8);
        check("R5", "sleep opcode with 9 bits", int'(pwr_state), ST_STBY);
        busy = 1'b1;
        run_frame(1'b0, 8'hB9, 8);
        idle(8);
        busy = 1'b0;
        check("R8", "sleep opcode while busy", int'(pwr_state), ST_STBY);
        run_frame(1'b0, 8'hB9, 8);
        idle(8);
        check("R5", "sleep opcode with 8 bits", int'(pwr_state), ST_DEEP);
    endtask

    task automatic t_deep_ignore();
        run_frame(1'b0, 8'h9F, 48);
        idle(8);
        check("R6", "oe for other opcode in deep", oe_count(0, 48), 0);
        check("R6", "power after other opcode", int'(pwr_state), ST_DEEP);
        run_frame(1'b1, 8'hB9, 8);
        idle(8);
        check("R6", "power after sleep opcode in deep", int'(pwr_state), ST_DEEP);
        busy = 1'b1;
        run_frame(1'b0, 8'hAB, 40);
        idle(8);
        busy = 1'b0;
        check("R8", "oe for wake opcode while busy", oe_count(0, 40), 0);
        check("R8", "power after wake opcode while busy", int'(pwr_state), ST_DEEP);
    endtask

    // wake, then start a long selection inside the delay
    task automatic t_wake_then_select(input logic [7:0] op, input int nbits);
        run_frame(1'b1, 8'hAB, 40);
        check("R7", "signature from deep", rx_byte(32), 'h14);
        idle(6);
        check("R7", "power just after release", int'(pwr_state), ST_WAKE);
        run_frame(1'b0, op, nbits);
        idle(8);
        check("R9", "oe for selection begun in wake", oe_count(0, nbits), 0);
        check("R9", "power after selection begun in wake", int'(pwr_state), ST_STBY);
    endtask

    task automatic t_wake_length();
        int cnt = 0;
        int guard = 0;
        run_frame(1'b0, 8'hAB, 33);
        while (pwr_state != 2'(ST_WAKE) && guard < 50) begin
            @(negedge clk);
            guard++;
        end
        while (pwr_state == 2'(ST_WAKE) && cnt < WAKE_CYC + 50) begin
            cnt++;
            @(negedge clk);
        end
        check("R7", "clocks spent waking", cnt, WAKE_CYC);
        check("R7", "power after wake interval", int'(pwr_state), ST_STBY);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog (all requirements): actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        idle(4);
        rst_n = 1'b1;
        idle(4);
        t_reset();
        t_sig_standby(1'b0);
        t_sig_standby(1'b1);
        t_sleep_counts();
        t_deep_ignore();
        t_wake_then_select(8'hAB, 48);
        run_frame(1'b0, 8'hB9, 8);
        idle(8);
        check("R5", "re-enter deep", int'(pwr_state), ST_DEEP);
        t_wake_then_select(8'hB9, 8);
        run_frame(1'b1, 8'hB9, 8);
        idle(8);
        check("R5", "enter deep in mode 3", int'(pwr_state), ST_DEEP);
        t_wake_length();
        summary();
        $finish;
    end
endmodule